// File: doc/BRIEF.md
# Splittable Performance Counter Bank

The block holds eight physical event counters behind a 64-bit register bus. Each physical counter counts as a single 32-bit value, or as two 16-bit halves that count separate events. A per-counter mode bit in the control register picks the mode. In split mode the two halves appear as two logical counters. Logical counter `k` (0 to 7) addresses the upper half of physical counter `k`. Logical counter `k+8` addresses its lower half.

A software write to a counter never lands directly in the running value. It is parked in a hold register for that counter, and a read returns the parked value while it is pending. Every pending value moves into its live counter at the moment software writes the control register with the run bit set. This also happens if the bank is already running. Clearing the run bit freezes all counting.

When a counter or half-counter wraps from all ones to zero, it raises a sticky flag in the status register. A status read returns the flags and clears them. A status write loads the interrupt mask. The interrupt output is high while any flag is set under the mask.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset all counters, hold registers, the control register, the flags, the mask, `bus_rdata` and `perf_irq` are zero.
- R2: Word addresses 0..15 are logical counters, 16 is control and 17 is status. A register's 32-bit value travels in `bus_wdata[63:32]` and `bus_rdata[63:32]`. `bus_wdata[31:0]` is ignored and `bus_rdata[31:0]` reads zero. Read data is registered and appears on the clock edge that samples `bus_rd`. It holds until the next read.
- R3: A counter write only loads that counter's hold register and marks it pending. A read of a pending counter returns the hold value.
- R4: A control write with bit 31 set copies every pending hold value into its live counter and clears all pending marks.
- R5: While control bit 31 is zero, no counter changes on events.
- R6: In full mode (control bit `p` = 0), `evt_inc[p]` adds one to the 32-bit counter and `evt_inc_lo[p]` has no effect. Logical indices `p` and `p+8` both read and write the whole counter.
- R7: In split mode (control bit `p` = 1), `evt_inc[p]` counts the upper 16 bits and `evt_inc_lo[p]` counts the lower 16 bits, with no carry between them. Reads return the addressed half zero-extended. A write to one half keeps the other half's current visible value.
- R8: A wrap of a full counter or an upper half sets status bit `p`. A wrap of a lower half sets status bit `8+p`.
- R9: A status read returns the flags as they stood before the access and clears them. A wrap in the same cycle stays set.
- R10: A status write loads the 16-bit interrupt mask. `perf_irq` is registered and equals the OR of (flags AND mask), updated on the same edge as the flags and mask. A zero mask keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 64 | Write data, value in the upper 32 bits |
| bus_rdata | output | 64 | Registered read data, value in the upper 32 bits |
| evt_inc | input | 8 | Event pulses for full counters or upper halves |
| evt_inc_lo | input | 8 | Event pulses for lower halves |
| perf_irq | output | 1 | Masked overflow interrupt, active high |

## Verification
All results are due one clock edge after their cause:
- Read data is due one edge after the `bus_rd` cycle.
- Counter values change one edge after each event cycle.
- A commit takes effect on the edge of the control write.
- Flags and `perf_irq` update on the same edge as the wrap, read or mask write that caused them.

The bench drives every stimulus on a falling edge and removes it on the next falling edge. It then samples at that second falling edge, which is half a cycle after the edge that must have produced the result. The bench does not wait on multi-cycle counts. Each event burst runs for an exact number of edges, and the expected count is derived from that number.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int BUS_W  = 64;
  localparam int REG_W  = 32;
  localparam int RUN_BIT = 31;
endpackage

// File: rtl/pcb_slice.sv
module pcb_slice #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          split,
  input  logic          commit,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [CW-1:0] wdata,
  input  logic          inc_hi,
  input  logic          inc_lo,
  output logic [CW-1:0] view,
  output logic          ovf_hi,
  output logic          ovf_lo
);
  localparam int HW = CW / 2;

  logic [CW-1:0] live_q, hold_q, live_n, hold_n;
  logic          pend_q, run, load;

  assign view = pend_q ? hold_q : live_q;
  assign load = commit && pend_q;
  assign run  = en && !load;

  assign ovf_hi = run && inc_hi && (split ? (&live_q[CW-1:HW]) : (&live_q));
  assign ovf_lo = run && split && inc_lo && (&live_q[HW-1:0]);

  always_comb begin
    live_n = live_q;
    if (load) begin
      live_n = hold_q;
    end else if (run) begin
      if (split) begin
        live_n[CW-1:HW] = live_q[CW-1:HW] + HW'(inc_hi);
        live_n[HW-1:0]  = live_q[HW-1:0] + HW'(inc_lo);
      end else begin
        live_n = live_q + CW'(inc_hi);
      end
    end
  end

  always_comb begin
    if (!split)     hold_n = wdata;
    else if (wr_hi) hold_n = {wdata[HW-1:0], view[HW-1:0]};
    else            hold_n = {view[CW-1:HW], wdata[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      live_q <= live_n;
      if (commit) pend_q <= 1'b0;
      if (wr_hi || wr_lo) begin
        hold_q <= hold_n;
        pend_q <= 1'b1;
      end
    end
  end

  // R3: a counter write leaves a pending value behind
  a_r3_write_pends: assert property (@(posedge clk) disable iff (rst)
    (wr_hi || wr_lo) |=> pend_q);
  // R4: commit moves the parked value into the live counter
  a_r4_commit_loads: assert property (@(posedge clk) disable iff (rst)
    load |=> (live_q == $past(hold_q)) && !pend_q);
  // R5: no change while stopped and not committing
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (!en && !commit) |=> $stable(live_q));
  // R7: upper half only moves on its own event
  a_r7_no_carry: assert property (@(posedge clk) disable iff (rst)
    (run && split && !inc_hi) |=> $stable(live_q[CW-1:HW]));
endmodule

// File: rtl/pcb_status.sv
module pcb_status #(
  parameter int NF = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] ovf,
  input  logic          rd_clr,
  input  logic          mask_wr,
  input  logic [NF-1:0] mask_d,
  output logic [NF-1:0] stat,
  output logic          irq
);
  logic [NF-1:0] stat_q, mask_q, stat_n, mask_n;
  logic          irq_q;

  assign stat_n = (rd_clr ? '0 : stat_q) | ovf;
  assign mask_n = mask_wr ? mask_d : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
      irq_q  <= |(stat_n & mask_n);
    end
  end

  assign stat = stat_q;
  assign irq  = irq_q;

  // R8: every wrap leaves its flag set
  a_r8_flag_sticks: assert property (@(posedge clk) disable iff (rst)
    (ovf != '0) |=> ((stat_q & $past(ovf)) == $past(ovf)));
  // R9: a read with no new wrap empties the flags
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ovf == '0) |=> (stat_q == '0));
  // R10: an empty mask keeps the interrupt low
  a_r10_quiet_mask: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0 && !mask_wr) |=> !irq_q);
  // R10: interrupt only with a masked flag present
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((stat_q & mask_q) != '0));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter  int NCNT = 8,
  parameter  int CW   = 32,
  localparam int AW   = $clog2(2 * NCNT) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [AW-1:0]             bus_addr,
  input  logic [pcb_pkg::BUS_W-1:0] bus_wdata,
  output logic [pcb_pkg::BUS_W-1:0] bus_rdata,
  input  logic [NCNT-1:0]           evt_inc,
  input  logic [NCNT-1:0]           evt_inc_lo,
  output logic                      perf_irq
);
  import pcb_pkg::*;

  localparam int LW     = $clog2(NCNT);
  localparam int HW     = CW / 2;
  localparam int NF     = 2 * NCNT;
  localparam int A_CTRL = 2 * NCNT;
  localparam int A_STAT = 2 * NCNT + 1;

  logic [REG_W-1:0] wval, rd_val;
  logic             unused_lo;
  logic             is_ctr, lowsel, commit;
  logic [LW-1:0]    phys;
  logic             run_q;
  logic [NCNT-1:0]  split_q;
  logic [CW-1:0]    view [NCNT];
  logic [NCNT-1:0]  ovf_hi, ovf_lo;
  logic [NF-1:0]    stat;

  assign wval      = bus_wdata[BUS_W-1:REG_W];
  assign unused_lo = ^bus_wdata[REG_W-1:0];
  assign is_ctr    = bus_addr < AW'(A_CTRL);
  assign phys      = bus_addr[LW-1:0];
  assign lowsel    = bus_addr[LW];
  assign commit    = bus_wr && bus_addr == AW'(A_CTRL) && wval[RUN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      split_q <= '0;
    end else if (bus_wr && bus_addr == AW'(A_CTRL)) begin
      run_q   <= wval[RUN_BIT];
      split_q <= wval[NCNT-1:0];
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_slice
    logic sel;
    assign sel = bus_wr && is_ctr && phys == LW'(i);
    pcb_slice #(.CW(CW)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .en     (run_q),
      .split  (split_q[i]),
      .commit (commit),
      .wr_hi  (sel && !lowsel),
      .wr_lo  (sel && lowsel),
      .wdata  (wval[CW-1:0]),
      .inc_hi (evt_inc[i]),
      .inc_lo (evt_inc_lo[i]),
      .view   (view[i]),
      .ovf_hi (ovf_hi[i]),
      .ovf_lo (ovf_lo[i])
    );
  end

  pcb_status #(.NF(NF)) u_status (
    .clk     (clk),
    .rst     (rst),
    .ovf     ({ovf_lo, ovf_hi}),
    .rd_clr  (bus_rd && bus_addr == AW'(A_STAT)),
    .mask_wr (bus_wr && bus_addr == AW'(A_STAT)),
    .mask_d  (wval[NF-1:0]),
    .stat    (stat),
    .irq     (perf_irq)
  );

  always_comb begin
    rd_val = '0;
    if (is_ctr) begin
      if (!split_q[phys])  rd_val = REG_W'(view[phys]);
      else if (lowsel)     rd_val = REG_W'(view[phys][HW-1:0]);
      else                 rd_val = REG_W'(view[phys][CW-1:HW]);
    end else if (bus_addr == AW'(A_CTRL)) begin
      rd_val[RUN_BIT]   = run_q;
      rd_val[NCNT-1:0]  = split_q;
    end else if (bus_addr == AW'(A_STAT)) begin
      rd_val = REG_W'(stat);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {rd_val, {REG_W{1'b0}}};
  end

  // R2: read data is held between reads
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_perf_counter_bank.sv
module tb_perf_counter_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  evt_inc = '0, evt_inc_lo = '0;
  logic        perf_irq;
  int          n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  perf_counter_bank dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_inc(evt_inc), .evt_inc_lo(evt_inc_lo), .perf_irq(perf_irq)
  );

  // {op, req, addr, data, expected}; op 0 write, 1 read, 2 events for addr+1 cycles
  localparam logic [74:0] VEC [24] = '{
    {2'd1, 4'd1,  5'd16, 32'h0,        32'h0},        // R1 control clear
    {2'd1, 4'd1,  5'd0,  32'h0,        32'h0},        // R1 counter clear
    {2'd0, 4'd3,  5'd0,  32'd100,      32'h0},        // R3 park 100
    {2'd1, 4'd3,  5'd0,  32'h0,        32'd100},      // R3 read parked
    {2'd2, 4'd5,  5'd4,  32'h01,       32'h0},        // R5 events while stopped
    {2'd1, 4'd6,  5'd8,  32'h0,        32'd100},      // R6 index 8 aliases full ctr 0
    {2'd0, 4'd4,  5'd16, 32'h80000000, 32'h0},        // R4 commit and run
    {2'd2, 4'd6,  5'd2,  32'h0101,     32'h0},        // R6 lo events ignored in full
    {2'd1, 4'd4,  5'd0,  32'h0,        32'd103},
    {2'd0, 4'd5,  5'd16, 32'h0,        32'h0},        // R5 stop
    {2'd2, 4'd5,  5'd3,  32'h01,       32'h0},
    {2'd1, 4'd5,  5'd0,  32'h0,        32'd103},
    {2'd0, 4'd7,  5'd16, 32'h2,        32'h0},        // R7 split ctr 1
    {2'd0, 4'd7,  5'd1,  32'h1234,     32'h0},
    {2'd0, 4'd7,  5'd9,  32'hFFFE,     32'h0},
    {2'd1, 4'd7,  5'd1,  32'h0,        32'h1234},
    {2'd1, 4'd7,  5'd9,  32'h0,        32'hFFFE},
    {2'd0, 4'd4,  5'd16, 32'h80000002, 32'h0},
    {2'd2, 4'd7,  5'd1,  32'h0202,     32'h0},        // R7 both halves, lo wraps
    {2'd1, 4'd7,  5'd1,  32'h0,        32'h1236},     // R7 no carry
    {2'd1, 4'd8,  5'd9,  32'h0,        32'h0},        // R8 lower wrapped
    {2'd1, 4'd8,  5'd17, 32'h0,        32'h200},      // R8 bit 8+1
    {2'd1, 4'd9,  5'd17, 32'h0,        32'h0},        // R9 cleared
    {2'd1, 4'd2,  5'd16, 32'h0,        32'h80000002}  // R2 control readback
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_rd(input logic [4:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] hi, input logic [7:0] lo, input int n);
    @(negedge clk);
    evt_inc = hi; evt_inc_lo = lo;
    repeat (n) @(negedge clk);
    evt_inc = '0; evt_inc_lo = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", {63'b0, perf_irq}, 64'h0);
    chk("R1", bus_rdata, 64'h0);

    for (int k = 0; k < 24; k++) begin
      logic [74:0] v;
      v = VEC[k];
      case (v[74:73])
        2'd0: do_wr(v[68:64], {v[63:32], 32'h0});
        2'd1: begin
          do_rd(v[68:64]);
          chk($sformatf("R%0d", v[72:69]), bus_rdata, {v[31:0], 32'h0});
        end
        default: pulse(v[39:32], v[47:40], int'(v[68:64]) + 1);
      endcase
    end

    // R2: low bus half ignored on write, zero on read
    do_wr(5'd3, {32'd5, 32'hDEADBEEF});
    do_rd(5'd3);
    chk("R2", bus_rdata, {32'd5, 32'h0});

    // R8 and R10: full counter wrap raises masked interrupt
    do_wr(5'd2, {32'hFFFFFFFF, 32'h0});
    do_wr(5'd16, {32'h80000002, 32'h0});
    do_wr(5'd17, {32'h4, 32'h0});
    pulse(8'h04, 8'h00, 1);
    chk("R10", {63'b0, perf_irq}, 64'h1);
    do_rd(5'd2);
    chk("R8", bus_rdata, 64'h0);
    do_rd(5'd17);
    chk("R9", bus_rdata, {32'h4, 32'h0});
    chk("R10", {63'b0, perf_irq}, 64'h0);

    // R9: wrap in the same cycle as a status read survives
    do_wr(5'd4, {32'hFFFFFFFF, 32'h0});
    do_wr(5'd16, {32'h80000002, 32'h0});
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'd17; evt_inc = 8'h10;
    @(negedge clk);
    bus_rd = 1'b0; evt_inc = '0;
    chk("R9", bus_rdata, 64'h0);
    do_wr(5'd17, {32'h10, 32'h0});
    chk("R10", {63'b0, perf_irq}, 64'h1);
    do_wr(5'd17, {32'h0, 32'h0});
    chk("R10", {63'b0, perf_irq}, 64'h0);
    do_rd(5'd17);
    chk("R9", bus_rdata, {32'h10, 32'h0});

    // R1: reset in mid run
    do_wr(5'd17, {32'hFFFF, 32'h0});
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R1", {63'b0, perf_irq}, 64'h0);
    do_rd(5'd16);
    chk("R1", bus_rdata, 64'h0);
    do_rd(5'd1);
    chk("R1", bus_rdata, 64'h0);
    do_rd(5'd17);
    chk("R1", bus_rdata, 64'h0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule